// File: doc/BRIEF.md
# Immediate-Offset Load Address Unit

This block takes a 64-bit base value and a raw immediate, works out the memory address for a load, and fetches a 32-bit word or a 64-bit doubleword through a simple request/response memory port. It also produces the new base value when the addressing mode updates its base register. There are three addressing modes. Post-index reads at the unchanged base and then moves the base by a signed byte offset. Pre-index moves the base first and reads at the moved address. Scaled unsigned offset reads at the base plus the immediate multiplied by the access size, and leaves the base unchanged.

The surrounding pipeline pulses `start` with the operands while `busy` is low. The unit issues one memory request, waits for the response, and then raises `done` for one cycle. In that cycle it presents the load result, zero-extended to 64 bits, along with the writeback enable and the writeback value. The base may come from a general register or from the stack pointer; the unit does not need to know which.

Top module: `imm_load_agu`

## Requirements
- R1: Post-index (`mode`=2'b00) requests address `base` and, at `done`, raises `wb_en` with `wb_data` = `base` + sign-extended `imm[8:0]`.
- R2: Pre-index (`mode`=2'b01) requests address `base` + sign-extended `imm[8:0]` and, at `done`, raises `wb_en` with `wb_data` equal to that same address.
- R3: Scaled unsigned offset (`mode`=2'b10 or 2'b11) requests `base` + (`imm[11:0]` << 2) for a word (`size_dw`=0) or `base` + (`imm[11:0]` << 3) for a doubleword (`size_dw`=1), and keeps `wb_en` low at `done`.
- R4: In the indexed modes only `imm[8:0]` counts, read as a two's-complement value from -256 to 255; `imm[11:9]` has no effect.
- R5: All address and writeback sums wrap modulo 2^64 and report no overflow.
- R6: For a word load, `result` = {32'b0, `mem_rsp_data[31:0]`}. For a doubleword load, `result` = `mem_rsp_data`. `mem_req_dw` equals the `size_dw` that was captured.
- R7: `mem_req_valid` rises in the cycle after `start` is accepted. It holds, with `mem_req_addr` stable, until a cycle in which `mem_req_ready` is high.
- R8: `done` is a one-cycle pulse in the cycle after `mem_rsp_valid` is sampled while the unit waits for a response. `result`, `wb_en` and `wb_data` are valid in that cycle, and `wb_en` is low in every other cycle.
- R9: A `start` pulse while `busy` is high is ignored. It changes neither the operation in flight nor the next memory request.
- R10: After reset, `busy`, `mem_req_valid`, `done` and `wb_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load; accepted only when idle |
| mode | input | 2 | 00 post-index, 01 pre-index, 1x scaled unsigned offset |
| size_dw | input | 1 | 0 word, 1 doubleword |
| base | input | 64 | Base register value |
| imm | input | 12 | Raw immediate field |
| busy | output | 1 | An operation is in flight |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Request byte address |
| mem_req_dw | output | 1 | Request size, 1 for doubleword |
| mem_rsp_valid | input | 1 | Response data valid |
| mem_rsp_data | input | 64 | Response data |
| done | output | 1 | Completion pulse |
| wb_en | output | 1 | Base writeback enable |
| wb_data | output | 64 | New base value |
| result | output | 64 | Zero-extended load result |

## Verification
A wrong latched address shows on `mem_req_addr` one cycle after `start`, before the memory port has accepted the request. A wrong writeback flag, writeback value or result register stays hidden until the `done` cycle, one cycle after the response arrives. Whether the other fields of the immediate are ignored, and whether `start` is ignored while busy, can only be seen in the addresses and values that follow. For that reason the bench checks every request address, checks every field in the `done` cycle, and checks the idle cycles after each operation.

// File: rtl/imm_load_pkg.sv
package imm_load_pkg;
  localparam int ADDR_W = 64;
  localparam int DATA_W = 64;
  localparam int IMM_W  = 12;
  localparam int SIMM_W = 9;
  localparam int WORD_W = DATA_W / 2;
  localparam int WORD_SHIFT  = 2;
  localparam int DWORD_SHIFT = 3;

  typedef enum logic [1:0] {
    AM_POST = 2'b00,
    AM_PRE  = 2'b01,
    AM_UOFF = 2'b10,
    AM_UOF2 = 2'b11
  } amode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_REQ  = 2'b01,
    ST_WAIT = 2'b10,
    ST_FIN  = 2'b11
  } lstate_e;

  function automatic logic [ADDR_W-1:0] sext_simm(input logic [IMM_W-1:0] raw);
    logic [SIMM_W-1:0] s;
    s = raw[SIMM_W-1:0];
    return {{(ADDR_W-SIMM_W){s[SIMM_W-1]}}, s};
  endfunction

  function automatic logic [ADDR_W-1:0] scale_uimm(input logic [IMM_W-1:0] raw,
                                                   input logic dw);
    logic [ADDR_W-1:0] z;
    z = {{(ADDR_W-IMM_W){1'b0}}, raw};
    return dw ? (z << DWORD_SHIFT) : (z << WORD_SHIFT);
  endfunction

  function automatic logic [DATA_W-1:0] fit_load(input logic [DATA_W-1:0] d,
                                                 input logic dw);
    return dw ? d : {{(DATA_W-WORD_W){1'b0}}, d[WORD_W-1:0]};
  endfunction
endpackage

// File: rtl/imm_load_addr.sv
module imm_load_addr
  import imm_load_pkg::*;
(
  input  logic [1:0]        mode,
  input  logic              size_dw,
  input  logic [ADDR_W-1:0] base,
  input  logic [IMM_W-1:0]  imm,
  output logic [ADDR_W-1:0] ea,
  output logic [ADDR_W-1:0] wb_val,
  output logic              wb_flag
);
  logic [ADDR_W-1:0] moved_base;
  logic [ADDR_W-1:0] scaled_ea;

  assign moved_base = base + sext_simm(imm);
  assign scaled_ea  = base + scale_uimm(imm, size_dw);

  always_comb begin
    ea      = scaled_ea;
    wb_val  = base;
    wb_flag = 1'b0;
    case (amode_e'(mode))
      AM_POST: begin
        ea      = base;
        wb_val  = moved_base;
        wb_flag = 1'b1;
      end
      AM_PRE: begin
        ea      = moved_base;
        wb_val  = moved_base;
        wb_flag = 1'b1;
      end
      default: begin
        ea      = scaled_ea;
        wb_val  = base;
        wb_flag = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/imm_load_seq.sv
module imm_load_seq
  import imm_load_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              size_dw,
  input  logic [ADDR_W-1:0] ea,
  input  logic [ADDR_W-1:0] wb_val,
  input  logic              wb_flag,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic              mem_req_dw,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              done,
  output logic              wb_en,
  output logic [ADDR_W-1:0] wb_data,
  output logic [DATA_W-1:0] result
);
  lstate_e           st_q;
  logic [ADDR_W-1:0] ea_q;
  logic [ADDR_W-1:0] wbv_q;
  logic              wbf_q;
  logic              dw_q;
  logic [DATA_W-1:0] res_q;

  logic start_accept;
  logic req_fire;
  logic rsp_take;

  assign start_accept = start && (st_q == ST_IDLE);
  assign req_fire     = (st_q == ST_REQ) && mem_req_ready;
  assign rsp_take     = (st_q == ST_WAIT) && mem_rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ea_q  <= '0;
      wbv_q <= '0;
      wbf_q <= 1'b0;
      dw_q  <= 1'b0;
      res_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_accept) begin
          st_q  <= ST_REQ;
          ea_q  <= ea;
          wbv_q <= wb_val;
          wbf_q <= wb_flag;
          dw_q  <= size_dw;
        end
        ST_REQ:  if (req_fire) st_q <= ST_WAIT;
        ST_WAIT: if (rsp_take) begin
          st_q  <= ST_FIN;
          res_q <= fit_load(mem_rsp_data, dw_q);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy          = (st_q != ST_IDLE);
  assign mem_req_valid = (st_q == ST_REQ);
  assign mem_req_addr  = ea_q;
  assign mem_req_dw    = dw_q;
  assign done          = (st_q == ST_FIN);
  assign wb_en         = done && wbf_q;
  assign wb_data       = wbv_q;
  assign result        = res_q;

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R7
  req_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> mem_req_valid);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  wb_only_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done);

  // R8
  done_follows_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(mem_rsp_valid));

  // R6
  word_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mem_req_dw) |-> (result[DATA_W-1:WORD_W] == '0));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

// File: rtl/imm_load_agu.sv
module imm_load_agu
  import imm_load_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic              size_dw,
  input  logic [ADDR_W-1:0] base,
  input  logic [IMM_W-1:0]  imm,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic              mem_req_dw,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              done,
  output logic              wb_en,
  output logic [ADDR_W-1:0] wb_data,
  output logic [DATA_W-1:0] result
);
  logic [ADDR_W-1:0] ea_w;
  logic [ADDR_W-1:0] wbv_w;
  logic              wbf_w;

  imm_load_addr u_addr (
    .mode    (mode),
    .size_dw (size_dw),
    .base    (base),
    .imm     (imm),
    .ea      (ea_w),
    .wb_val  (wbv_w),
    .wb_flag (wbf_w)
  );

  imm_load_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .size_dw       (size_dw),
    .ea            (ea_w),
    .wb_val        (wbv_w),
    .wb_flag       (wbf_w),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_req_dw    (mem_req_dw),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .done          (done),
    .wb_en         (wb_en),
    .wb_data       (wb_data),
    .result        (result)
  );

  // R3
  uoff_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode[1]) |-> !wbf_w);
endmodule

// File: tb/imm_load_agu_bench.sv
module imm_load_agu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        size_dw = 1'b0;
  logic [63:0] base = '0;
  logic [11:0] imm = '0;
  logic        busy, mem_req_valid, mem_req_dw, done, wb_en;
  logic        mem_req_ready = 1'b0;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic [63:0] mem_req_addr, wb_data, result;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  imm_load_agu u_imm_load_agu (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .size_dw(size_dw),
    .base(base), .imm(imm), .busy(busy), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_req_dw(mem_req_dw), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .wb_en(wb_en),
    .wb_data(wb_data), .result(result)
  );

  typedef struct packed {
    logic [3:0]  rq;
    logic [1:0]  md;
    logic        dw;
    logic [63:0] b;
    logic [11:0] im;
    logic [63:0] d;
    logic [63:0] ea;
    logic        wb;
    logic [63:0] wbv;
    logic [63:0] res;
  } vec_t;

  localparam logic [63:0] DAT = 64'h1122_3344_5566_7788;
  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    // R1 post word
    '{4'd1, 2'b00, 1'b0, 64'h1000, 12'h010, DAT, 64'h1000, 1'b1, 64'h1010, 64'h5566_7788},
    // R2 pre dword, negative offset
    '{4'd2, 2'b01, 1'b1, 64'h1000, 12'h1F0, DAT, 64'h0FF0, 1'b1, 64'h0FF0, DAT},
    // R3 word max offset 16380
    '{4'd3, 2'b10, 1'b0, 64'h2000, 12'hFFF, DAT, 64'h5FFC, 1'b0, 64'h0, 64'h5566_7788},
    // R3 dword max offset 32760
    '{4'd3, 2'b10, 1'b1, 64'h2000, 12'hFFF, DAT, 64'h9FF8, 1'b0, 64'h0, DAT},
    // R5 post dword -256 wraps below zero
    '{4'd5, 2'b00, 1'b1, 64'h0, 12'h100, DAT, 64'h0, 1'b1, 64'hFFFF_FFFF_FFFF_FF00, DAT},
    // R5 pre word +255 wraps past top
    '{4'd5, 2'b01, 1'b0, 64'hFFFF_FFFF_FFFF_FFF0, 12'h0FF, 64'hDEAD_BEEF_0BAD_F00D,
      64'hEF, 1'b1, 64'hEF, 64'h0BAD_F00D},
    // R3 zero offset default
    '{4'd3, 2'b10, 1'b1, 64'h1234, 12'h000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234, 1'b0, 64'h0,
      64'hFFFF_FFFF_FFFF_FFFF},
    // R4 upper imm bits ignored in indexed mode
    '{4'd4, 2'b00, 1'b0, 64'h40, 12'hE05, DAT, 64'h40, 1'b1, 64'h45, 64'h5566_7788},
    // R3 mode 11 also scaled unsigned
    '{4'd3, 2'b11, 1'b0, 64'h0, 12'h001, DAT, 64'h4, 1'b0, 64'h0, 64'h5566_7788}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Starts at a negedge, issues one op with immediate ready, ends at negedge of done cycle.
  task automatic run_op(input vec_t v, input int ready_delay);
    string t;
    t = $sformatf("R%0d", v.rq);
    mode = v.md; size_dw = v.dw; base = v.b; imm = v.im; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({t, " R7 req_valid"}, {63'd0, mem_req_valid}, 64'd1);
    chk({t, " addr"}, mem_req_addr, v.ea);
    chk({t, " R6 req_dw"}, {63'd0, mem_req_dw}, {63'd0, v.dw});
    for (int k = 0; k < ready_delay; k++) begin
      @(negedge clk);
      chk("R7 held valid", {63'd0, mem_req_valid}, 64'd1);
      chk("R7 held addr", mem_req_addr, v.ea);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b1; mem_rsp_data = v.d;
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    chk({t, " R8 done"}, {63'd0, done}, 64'd1);
    chk({t, " wb_en"}, {63'd0, wb_en}, {63'd0, v.wb});
    if (v.wb) chk({t, " wb_data"}, wb_data, v.wbv);
    chk({t, " R6 result"}, result, v.res);
    @(negedge clk);
    chk("R8 done drops", {62'd0, done, wb_en}, 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset outs", {60'd0, busy, mem_req_valid, done, wb_en}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 idle after reset", {60'd0, busy, mem_req_valid, done, wb_en}, 64'd0);

    for (int i = 0; i < NV; i++) run_op(VECS[i], 0);

    // R7 backpressure: ready low for three cycles
    run_op(VECS[1], 3);

    // R9 start during busy is ignored
    begin
      vec_t v;
      v = VECS[0];
      mode = v.md; size_dw = v.dw; base = v.b; imm = v.im; start = 1'b1;
      @(negedge clk);
      mode = 2'b01; size_dw = 1'b1; base = 64'h9999_0000; imm = 12'h020;
      chk("R9 first addr", mem_req_addr, v.ea);
      @(negedge clk);
      chk("R9 addr kept", mem_req_addr, v.ea);
      start = 1'b0;
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      start = 1'b1;
      mem_rsp_valid = 1'b1; mem_rsp_data = v.d;
      @(negedge clk);
      start = 1'b0;
      mem_rsp_valid = 1'b0;
      chk("R9 done", {63'd0, done}, 64'd1);
      chk("R9 wb_data unchanged", wb_data, v.wbv);
      chk("R9 result word", result, v.res);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk("R9 no extra request", {62'd0, mem_req_valid, busy}, 64'd0);
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule